// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Detection and Turbo Current Control

This block sits between the two counter chains of a frequency synthesizer and the charge pump. Each cycle it may receive a one-cycle strobe from the divided reference (`ref_pulse`) and a one-cycle strobe from the divided oscillator (`fb_pulse`). A three-state detector turns the order and spacing of these strobes into pump commands. A phase lead of the reference raises the "ahead" state and a lead of the feedback raises the "behind" state. Once both states are set, they clear after a deliberate one-cycle hold, which keeps narrow corrections from falling into a dead zone. A polarity input chooses which pump output carries the "ahead" state, so the block suits oscillators whose tuning slope is either positive or negative.

For every comparison the block measures how many clock cycles exactly one state was high. When that width is below a programmable window for a run of comparisons, it declares lock. When the width reaches the window or exceeds it for a shorter run of comparisons, it drops lock. A 3-bit drive level goes to the charge pump.
- While acquiring, it selects a large boost current if boost is enabled.
- Otherwise it passes on the 2-bit current code chosen by the selected register set.

Boost is armed only by reset or by a re-acquire strobe, and it is released when lock is gained. It does not return when lock is later lost.

All inputs are control-style pins sampled on the rising clock edge. The block has no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `pfd_lock_ctrl`

## Requirements
- R1: `pump_up` and `pump_dn` are high together for at most two consecutive cycles per comparison. After that, at least one of them is low, unless both strobes arrive on the very edge that clears them.
- R2: With `polarity`=1, a reference strobe that leads raises `pump_up` (source) and leaves `pump_dn` low. With `polarity`=0, the same event raises `pump_dn` instead. A feedback strobe that leads produces the mirror image.
- R3: When boost is inactive, `drive_level` = {1'b0, `cp_code`}. The codes mean 00 = 150 uA, 01 = 210 uA, 10 = 300 uA and 11 = 425 uA.
- R4: When boost is active, `drive_level` = 3'b100, which means about 2100 uA. Boost becomes active only after reset, or after a re-acquire strobe, while `turbo_en` is 1. It is never active while `turbo_en` is 0.
- R5: `locked` rises on the edge that completes the LOCK_RUN-th consecutive good comparison. A comparison is good when its error width is strictly below `lock_window`. `locked` is 0 out of reset.
- R6: Boost is released on the edge where `locked` rises. It stays released when lock is later lost, so `drive_level` then shows the programmed code.
- R7: While locked, `locked` falls on the edge that completes the UNLOCK_RUN-th consecutive bad comparison.
- R8: A one-cycle `reacq` strobe clears `locked` and both run counters. It re-arms boost when `turbo_en` is 1, and leaves boost off when `turbo_en` is 0.
- R9: A bad comparison restarts the good run before lock. A good comparison restarts the bad run while locked.
- R10: A comparison whose error width equals `lock_window` counts as bad. A width of `lock_window`-1 counts as good.
- R11: After the later strobe of a comparison, both pump outputs stay high for exactly two cycles, then clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | One-cycle strobe from the divided reference |
| fb_pulse | input | 1 | One-cycle strobe from the divided oscillator |
| polarity | input | 1 | 1: reference lead sources current; 0: reversed |
| turbo_en | input | 1 | Allows boost current during acquisition |
| cp_code | input | 2 | Programmed pump current code used after lock |
| lock_window | input | WIN_W | Error width limit in clock cycles |
| reacq | input | 1 | One-cycle re-acquire strobe |
| pump_up | output | 1 | Source-current command |
| pump_dn | output | 1 | Sink-current command |
| drive_level | output | 3 | Pump magnitude code (3'b100 = boost) |
| locked | output | 1 | Lock flag |

## Verification
The bench builds the block with its default parameters: WIN_W=6, LOCK_RUN=16 and UNLOCK_RUN=4, with the window set to 8 cycles. These values keep a full lock run, and the loss of lock after it, within a few hundred cycles. They also let the bench place the error width exactly at the window and one below it. Lock and unlock are checked one comparison before the threshold run and on the threshold run itself. The scenarios include a good run broken by a single bad comparison, boost re-arming with and without `turbo_en`, and simultaneous strobes.

// File: rtl/pfdl_pkg.sv
package pfdl_pkg;
  localparam int LEVEL_W = 3;
  typedef logic [1:0]         cp_code_t;
  typedef logic [LEVEL_W-1:0] level_t;
  localparam level_t LEVEL_BOOST = 3'b100;

  function automatic level_t pick_level(input logic boost, input cp_code_t code);
    return boost ? LEVEL_BOOST : {1'b0, code};
  endfunction
endpackage

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int ERR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_pulse,
  input  logic             fb_pulse,
  output logic             ahead_q,
  output logic             behind_q,
  output logic             cmp_done,
  output logic [ERR_W-1:0] err_width
);
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  logic clr_q;
  logic [ERR_W-1:0] err_cnt;

  // The clear is taken one cycle after both states are seen high (anti dead zone).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ahead_q  <= 1'b0;
      behind_q <= 1'b0;
      clr_q    <= 1'b0;
      err_cnt  <= '0;
    end else begin
      clr_q <= ahead_q & behind_q & ~clr_q;
      if (clr_q) begin
        ahead_q  <= ref_pulse;
        behind_q <= fb_pulse;
        err_cnt  <= '0;
      end else begin
        ahead_q  <= ahead_q | ref_pulse;
        behind_q <= behind_q | fb_pulse;
        if ((ahead_q ^ behind_q) && err_cnt != ERR_MAX)
          err_cnt <= err_cnt + 1'b1;
      end
    end
  end

  assign cmp_done  = clr_q;
  assign err_width = err_cnt;

  assert_overlap_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ahead_q && behind_q && clr_q && !(ref_pulse && fb_pulse)) |=> !(ahead_q && behind_q));

  assert_ref_lead_sets_ahead_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_q && ref_pulse && !fb_pulse && !behind_q) |=> (ahead_q && !behind_q));

  assert_clear_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ahead_q && behind_q && !clr_q) |=> (ahead_q && behind_q && clr_q));
endmodule

// File: rtl/lock_detect.sv
module lock_detect #(
  parameter int WIN_W      = 6,
  parameter int LOCK_RUN   = 16,
  parameter int UNLOCK_RUN = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmp_done,
  input  logic [WIN_W:0] err_width,
  input  logic [WIN_W-1:0] window,
  input  logic           reacq,
  output logic           locked,
  output logic           lock_set
);
  localparam int GOOD_W = $clog2(LOCK_RUN + 1);
  localparam int BAD_W  = $clog2(UNLOCK_RUN + 1);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_RUN - 1);
  localparam logic [BAD_W-1:0]  BAD_LAST  = BAD_W'(UNLOCK_RUN - 1);

  logic [GOOD_W-1:0] good_cnt;
  logic [BAD_W-1:0]  bad_cnt;
  logic              good;

  assign good     = err_width < {1'b0, window};
  assign lock_set = !reacq && cmp_done && !locked && good && good_cnt == GOOD_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      good_cnt <= '0;
      bad_cnt  <= '0;
    end else if (reacq) begin
      locked   <= 1'b0;
      good_cnt <= '0;
      bad_cnt  <= '0;
    end else if (cmp_done) begin
      if (!locked) begin
        if (!good)                     good_cnt <= '0;
        else if (good_cnt == GOOD_LAST) begin
          locked   <= 1'b1;
          good_cnt <= '0;
          bad_cnt  <= '0;
        end else                       good_cnt <= good_cnt + 1'b1;
      end else begin
        if (good)                      bad_cnt <= '0;
        else if (bad_cnt == BAD_LAST) begin
          locked   <= 1'b0;
          good_cnt <= '0;
          bad_cnt  <= '0;
        end else                       bad_cnt <= bad_cnt + 1'b1;
      end
    end
  end

  assert_lock_after_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(good_cnt) == GOOD_LAST && $past(cmp_done)));

  assert_unlock_after_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(locked) && !$past(reacq)) |-> ($past(bad_cnt) == BAD_LAST && $past(cmp_done)));

  assert_reacq_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reacq |=> !locked);
endmodule

// File: rtl/boost_ctrl.sv
module boost_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic turbo_en,
  input  logic reacq,
  input  logic lock_set,
  output logic boost_on
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed <= 1'b1;
    else if (!turbo_en) armed <= 1'b0;
    else if (reacq)     armed <= 1'b1;
    else if (lock_set)  armed <= 1'b0;
  end

  assign boost_on = armed & turbo_en;

  assert_boost_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!turbo_en && !reacq) |=> !armed);
endmodule

// File: rtl/pfd_lock_ctrl.sv
module pfd_lock_ctrl
  import pfdl_pkg::*;
#(
  parameter int WIN_W      = 6,
  parameter int LOCK_RUN   = 16,
  parameter int UNLOCK_RUN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_pulse,
  input  logic             fb_pulse,
  input  logic             polarity,
  input  logic             turbo_en,
  input  logic [1:0]       cp_code,
  input  logic [WIN_W-1:0] lock_window,
  input  logic             reacq,
  output logic             pump_up,
  output logic             pump_dn,
  output logic [2:0]       drive_level,
  output logic             locked
);
  localparam int ERR_W = WIN_W + 1;

  logic             ahead_q, behind_q, cmp_done, lock_set, boost_on;
  logic [ERR_W-1:0] err_width;

  pfd_core #(.ERR_W(ERR_W)) u_core (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .ahead_q(ahead_q), .behind_q(behind_q), .cmp_done(cmp_done), .err_width(err_width)
  );

  lock_detect #(.WIN_W(WIN_W), .LOCK_RUN(LOCK_RUN), .UNLOCK_RUN(UNLOCK_RUN)) u_lock (
    .clk(clk), .rst_n(rst_n), .cmp_done(cmp_done), .err_width(err_width),
    .window(lock_window), .reacq(reacq), .locked(locked), .lock_set(lock_set)
  );

  boost_ctrl u_boost (
    .clk(clk), .rst_n(rst_n), .turbo_en(turbo_en), .reacq(reacq),
    .lock_set(lock_set), .boost_on(boost_on)
  );

  always_comb begin
    pump_up     = polarity ? ahead_q : behind_q;
    pump_dn     = polarity ? behind_q : ahead_q;
    drive_level = pick_level(boost_on, cp_code);
  end

  assert_no_boost_when_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> drive_level[2] == 1'b0);
endmodule

// File: tb/pfd_lock_ctrl_test.sv
`timescale 1ns/1ps
module pfd_lock_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_p = 0, fb_p = 0, pol = 1, ten = 1, reacq = 0;
  logic [1:0] code = 2'b10;
  logic [5:0] win = 6'd8;
  logic up, dn, lk;
  logic [2:0] lvl;
  int checks = 0, fails = 0, both_run = 0, both_max = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pfd_lock_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_p), .fb_pulse(fb_p), .polarity(pol),
    .turbo_en(ten), .cp_code(code), .lock_window(win), .reacq(reacq),
    .pump_up(up), .pump_dn(dn), .drive_level(lvl), .locked(lk)
  );

  always @(negedge clk) if (rst_n) begin
    if (up && dn) both_run++; else both_run = 0;
    if (both_run > both_max) both_max = both_run;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmp(input int k);
    @(negedge clk); ref_p = 1; fb_p = (k == 0);
    @(negedge clk); ref_p = 0; fb_p = 0;
    if (k > 0) begin
      repeat (k - 1) @(negedge clk);
      fb_p = 1;
      @(negedge clk); fb_p = 0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_reacq();
    @(negedge clk); reacq = 1;
    @(negedge clk); reacq = 0;
  endtask

  task automatic t_reset();
    chk("R5 reset lock", lk, 0);
    chk("R1 reset pumps", {up, dn}, 0);
    chk("R4 boost at power-up", lvl, 3'b100);
  endtask

  task automatic t_polarity();
    pulse_reacq();
    pol = 1;
    @(negedge clk); ref_p = 1;
    @(negedge clk); ref_p = 0;
    chk("R2 pol1 ref lead", {up, dn}, 2'b10);
    repeat (2) @(negedge clk); fb_p = 1;
    @(negedge clk); fb_p = 0;
    chk("R11 overlap cycle 1", {up, dn}, 2'b11);
    @(negedge clk);
    chk("R11 overlap cycle 2", {up, dn}, 2'b11);
    @(negedge clk);
    chk("R11 cleared", {up, dn}, 2'b00);
    pol = 0;
    @(negedge clk); ref_p = 1;
    @(negedge clk); ref_p = 0;
    chk("R2 pol0 ref lead", {up, dn}, 2'b01);
    @(negedge clk); fb_p = 1;
    @(negedge clk); fb_p = 0;
    repeat (4) @(negedge clk);
    pol = 1;
    @(negedge clk); fb_p = 1;
    @(negedge clk); fb_p = 0;
    chk("R2 pol1 fb lead", {up, dn}, 2'b01);
    @(negedge clk); ref_p = 1;
    @(negedge clk); ref_p = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_lock_and_unlock();
    pulse_reacq();
    code = 2'b01;
    repeat (15) cmp(2);
    chk("R5 15 good not locked", lk, 0);
    chk("R4 boost during acquisition", lvl, 3'b100);
    cmp(2);
    chk("R5 16 good locked", lk, 1);
    chk("R6 boost released", lvl, 3'b001);
    repeat (3) cmp(8);
    chk("R7 3 bad still locked", lk, 1);
    cmp(8);
    chk("R7 4 bad unlocked", lk, 0);
    chk("R6 no boost after loss", lvl, 3'b001);
  endtask

  task automatic t_window();
    pulse_reacq();
    repeat (16) cmp(7);
    chk("R10 width window-1 good", lk, 1);
    pulse_reacq();
    repeat (16) cmp(8);
    chk("R10 width equal window bad", lk, 0);
  endtask

  task automatic t_runs();
    pulse_reacq();
    repeat (10) cmp(1);
    cmp(9);
    repeat (15) cmp(0);
    chk("R9 good run restarted", lk, 0);
    cmp(0);
    chk("R9 lock after fresh run", lk, 1);
    repeat (3) cmp(9);
    cmp(1);
    repeat (3) cmp(9);
    chk("R9 bad run restarted", lk, 1);
  endtask

  task automatic t_levels();
    ten = 0;
    for (int c = 0; c < 4; c++) begin
      code = 2'(c);
      @(negedge clk);
      chk("R3 level map", lvl, c);
    end
    ten = 1; code = 2'b11;
    @(negedge clk); @(negedge clk);
    chk("R4 enable alone no boost", lvl, 3'b011);
    ten = 0;
    pulse_reacq();
    chk("R8 reacq clears lock", lk, 0);
    chk("R8 no boost without enable", lvl, 3'b011);
    ten = 1;
    pulse_reacq();
    chk("R8 reacq re-arms boost", lvl, 3'b100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_polarity();
    t_lock_and_unlock();
    t_window();
    t_runs();
    t_levels();
    chk("R1 overlap run max", both_max, 2);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule